// File: doc/BRIEF.md
# XOR-Encoded Multi-Port Register File

This block is a register file of 256 words of 32 bits. It has three write ports and four read ports, and every port is served in the same clock cycle with no time sharing. Each write port owns a storage bank. A write does not store its data directly. It stores the data XORed with what the other two banks hold at that address. The word seen by a reader is therefore the XOR of all three banks at the address, and it equals the last value written there, whichever port wrote it.

Bank contents are read combinationally, both to form the encoded write data and to serve the readers. Each bank is therefore kept as several identical copies, so that no copy is read by more than one consumer. For a bank, one copy serves each of the other write ports and one copy serves each read port. All copies of a bank are written together in the same cycle, with the same address and the same encoded data.

Read results are registered and appear one cycle after a read is enabled. A combinational flag warns when two enabled write ports target the same address in the same cycle. No write order is defined for that case.

Top module: `xor_regfile`

## Requirements
- R1: The default geometry is 256 words of 32 bits, with 3 write ports and 4 read ports, and all ports act in the same clock cycle.
- R2: A word written through any write port is returned by any read port that reads the same address in a later cycle.
- R3: When `rd_en[r]` is high at a rising edge, `rd_data[r]` shows the word at `rd_addr[r]` from that edge until the next update, which gives a latency of one cycle.
- R4: While `rd_en[r]` is low, `rd_data[r]` holds its previous value, whatever `rd_addr[r]` does.
- R5: A read of an address that is written in the same cycle returns the value stored before that write. The new value is returned from the next cycle.
- R6: Three writes to three distinct addresses in one cycle are all kept.
- R7: When different ports write the same address in successive cycles, a read returns the most recent value. For example, writing 0xA through port 0 and then 0x7 through port 1 reads back as 0x7.
- R8: `wr_clash` is high in the same cycle whenever two or more enabled write ports present equal addresses. It is low otherwise, including when only disabled ports share an address.
- R9: While `rst_n` is low, every `rd_data` word is cleared to zero. The storage itself is not initialised.
- R10: The four read ports use independent addresses in the same cycle, and each port returns its own word.
- R11: A write port with `wr_en[p]` low changes no stored word, whatever its address and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all writes and read registers update on the rising edge |
| rst_n | input | 1 | Active-low reset of the read output registers |
| wr_en | input | 3 | Write enable for each write port |
| wr_addr | input | 3x8 | Write address for each write port |
| wr_data | input | 3x32 | Write data for each write port |
| rd_en | input | 4 | Read enable for each read port |
| rd_addr | input | 4x8 | Read address for each read port |
| rd_data | output | 4x32 | Registered read data for each read port |
| wr_clash | output | 1 | High when two enabled write ports share an address |

## Verification
Read words are due one rising edge after the cycle that presents `rd_en` and `rd_addr`. The bench's driver tags each expected word with that due cycle and pushes it onto a scoreboard queue. A monitor running on the falling edge pops only the items whose due cycle has been reached. The expected word is taken from a single-array reference model before that cycle's writes are applied to it, which captures the old-value behaviour for reads of an address being written. `wr_clash` is combinational, so it is checked one nanosecond after the inputs change, within the same cycle.

// File: rtl/xor_regfile.sv
module xor_regfile #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 32,
  parameter int NWR   = 3,
  parameter int NRD   = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NWR-1:0]             wr_en,
  input  logic [NWR-1:0][AW-1:0]     wr_addr,
  input  logic [NWR-1:0][WIDTH-1:0]  wr_data,
  input  logic [NRD-1:0]             rd_en,
  input  logic [NRD-1:0][AW-1:0]     rd_addr,
  output logic [NRD-1:0][WIDTH-1:0]  rd_data,
  output logic                       wr_clash
);
  localparam int NCOPY = NWR - 1 + NRD;

  logic [NWR-1:0][WIDTH-1:0] enc;

  // bank b, copy c: copies 0..NWR-2 feed the other writers, the rest feed readers
  for (genvar b = 0; b < NWR; b++) begin : gen_mem
    for (genvar c = 0; c < NCOPY; c++) begin : gen_cp
      logic [WIDTH-1:0] store [DEPTH];
      always_ff @(posedge clk)
        if (wr_en[b]) store[wr_addr[b]] <= enc[b];
    end
  end

  for (genvar b = 0; b < NWR; b++) begin : gen_enc
    for (genvar p = 0; p < NWR; p++) begin : gen_peer
      logic [WIDTH-1:0] term;
      logic [WIDTH-1:0] acc;
      if (p == b) begin : g_self
        assign term = '0;
      end else begin : g_other
        localparam int CI = (b < p) ? b : b - 1;
        assign term = gen_mem[p].gen_cp[CI].store[wr_addr[b]];
      end
      if (p == 0) begin : g_first
        assign acc = wr_data[b] ^ term;
      end else begin : g_next
        assign acc = gen_peer[p-1].acc ^ term;
      end
    end
    assign enc[b] = gen_peer[NWR-1].acc;
  end

  for (genvar r = 0; r < NRD; r++) begin : gen_rd
    localparam int CI = NWR - 1 + r;
    for (genvar b = 0; b < NWR; b++) begin : gen_bk
      logic [WIDTH-1:0] acc;
      if (b == 0) begin : g_first
        assign acc = gen_mem[0].gen_cp[CI].store[rd_addr[r]];
      end else begin : g_next
        assign acc = gen_bk[b-1].acc ^ gen_mem[b].gen_cp[CI].store[rd_addr[r]];
      end
    end
    logic [WIDTH-1:0] q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        q <= '0;
      else if (rd_en[r]) q <= gen_bk[NWR-1].acc;
    assign rd_data[r] = q;
  end

  always_comb begin
    wr_clash = 1'b0;
    for (int i = 0; i < NWR; i++)
      for (int j = i + 1; j < NWR; j++)
        if (wr_en[i] && wr_en[j] && wr_addr[i] == wr_addr[j]) wr_clash = 1'b1;
  end
endmodule

// File: rtl/xor_regfile_chk.sv
module xor_regfile_chk #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 32,
  parameter int NWR   = 3,
  parameter int NRD   = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NWR-1:0]             wr_en,
  input logic [NWR-1:0][AW-1:0]     wr_addr,
  input logic [NRD-1:0]             rd_en,
  input logic [NRD-1:0][WIDTH-1:0]  rd_data,
  input logic                       wr_clash
);
  for (genvar i = 0; i < NWR; i++) begin : g_pi
    for (genvar j = i + 1; j < NWR; j++) begin : g_pj
      p_clash_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[i] && wr_en[j] && wr_addr[i] == wr_addr[j]) |-> wr_clash);
    end
  end

  p_clash_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(wr_en) < 2) |-> !wr_clash);

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en[r] |=> $stable(rd_data[r]));
  end

  p_rd_reset_r9: assert property (@(posedge clk)
    !rst_n |=> (rd_data == '0));
endmodule

bind xor_regfile xor_regfile_chk #(
  .DEPTH(DEPTH), .WIDTH(WIDTH), .NWR(NWR), .NRD(NRD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .rd_en(rd_en), .rd_data(rd_data), .wr_clash(wr_clash)
);

// File: tb/xor_regfile_tb.sv
`timescale 1ns/1ps
module xor_regfile_tb;
  localparam int DEPTH = 256;
  localparam int W     = 32;
  localparam int NWR   = 3;
  localparam int NRD   = 4;
  localparam int AW    = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                     rst_n;
  logic [NWR-1:0]           wr_en;
  logic [NWR-1:0][AW-1:0]   wr_addr;
  logic [NWR-1:0][W-1:0]    wr_data;
  logic [NRD-1:0]           rd_en;
  logic [NRD-1:0][AW-1:0]   rd_addr;
  logic [NRD-1:0][W-1:0]    rd_data;
  logic                     wr_clash;

  xor_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .wr_clash(wr_clash)
  );

  typedef struct {
    int          due;
    int          port;
    logic [W-1:0] exp;
    string       tag;
  } item_t;

  item_t        sbq[$];
  logic [W-1:0] model [DEPTH];
  logic [W-1:0] last_exp [NRD];
  int cyc = 0, total = 0, bad = 0;
  bit done = 1'b0;

  logic [NWR-1:0]         s_we;
  logic [NWR-1:0][AW-1:0] s_wa;
  logic [NWR-1:0][W-1:0]  s_wd;
  logic [NRD-1:0]         s_re;
  logic [NRD-1:0][AW-1:0] s_ra;

  always @(posedge clk) cyc++;

  // monitor: compare each scoreboard item in the cycle it falls due
  item_t it;
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      it = sbq.pop_front();
      total++;
      if (rd_data[it.port] !== it.exp) begin
        bad++;
        $display("FAIL %s port%0d actual=%h expected=%h", it.tag, it.port, rd_data[it.port], it.exp);
      end
    end
  end

  task automatic clear_stage();
    s_we = '0; s_wa = '0; s_wd = '0; s_re = '0; s_ra = '0;
  endtask

  // driver: apply staged inputs, check clash, push expected reads, update model
  task automatic step(string tag);
    bit clash_exp;
    item_t ni;
    @(negedge clk);
    wr_en = s_we; wr_addr = s_wa; wr_data = s_wd; rd_en = s_re; rd_addr = s_ra;
    #1;
    clash_exp = 1'b0;
    for (int i = 0; i < NWR; i++)
      for (int j = i + 1; j < NWR; j++)
        if (s_we[i] && s_we[j] && s_wa[i] == s_wa[j]) clash_exp = 1'b1;
    total++;
    if (wr_clash !== clash_exp) begin
      bad++;
      $display("FAIL R8 %s clash actual=%b expected=%b", tag, wr_clash, clash_exp);
    end
    for (int r = 0; r < NRD; r++) begin
      ni.due  = cyc + 1;
      ni.port = r;
      ni.exp  = s_re[r] ? model[s_ra[r]] : last_exp[r];
      ni.tag  = tag;
      last_exp[r] = ni.exp;
      sbq.push_back(ni);
    end
    for (int p = 0; p < NWR; p++)
      if (s_we[p]) model[s_wa[p]] = clash_exp ? 'x : s_wd[p];
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NRD; r++) last_exp[r] = '0;
    rst_n = 1'b0;
    wr_en = '0; wr_addr = '0; wr_data = '0; rd_en = '0; rd_addr = '0;
    clear_stage();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R9: outputs zero after reset
    step("R9 reset");
    step("R9 reset");

    // R6: fill all words, three distinct addresses per cycle
    for (int a = 0; a < DEPTH; a += 3) begin
      clear_stage();
      for (int p = 0; p < NWR; p++)
        if (a + p < DEPTH) begin
          s_we[p] = 1'b1; s_wa[p] = AW'(a + p); s_wd[p] = $urandom;
        end
      step("R6 fill");
    end

    // R1 R2 R3 R10: read back every word on four independent ports
    for (int a = 0; a < DEPTH; a += 4) begin
      clear_stage();
      s_re = '1;
      for (int r = 0; r < NRD; r++) s_ra[r] = AW'(a + r);
      step("R1 R2 R3 R10 readback");
    end

    // R4: reads disabled, addresses moving
    for (int k = 0; k < 3; k++) begin
      clear_stage();
      for (int r = 0; r < NRD; r++) s_ra[r] = AW'($urandom);
      step("R4 hold");
    end

    // R7: successive writes through different ports to one address
    clear_stage(); s_we[0] = 1'b1; s_wa[0] = 8'd12; s_wd[0] = 32'h0000_000A; step("R7 a");
    clear_stage(); s_we[1] = 1'b1; s_wa[1] = 8'd12; s_wd[1] = 32'h0000_0007; step("R7 b");
    clear_stage(); s_re[0] = 1'b1; s_ra[0] = 8'd12; s_re[3] = 1'b1; s_ra[3] = 8'd12; step("R7 read");
    clear_stage(); s_we[2] = 1'b1; s_wa[2] = 8'd12; s_wd[2] = 32'h5A5A_1234; step("R7 c");
    clear_stage(); s_re[1] = 1'b1; s_ra[1] = 8'd12; s_re[2] = 1'b1; s_ra[2] = 8'd12; step("R7 read2");

    // R5: read during write of the same address returns old value
    clear_stage(); s_we[1] = 1'b1; s_wa[1] = 8'd40; s_wd[1] = 32'hCAFE_0040;
    s_re[0] = 1'b1; s_ra[0] = 8'd40; step("R5 same cycle");
    clear_stage(); s_re[0] = 1'b1; s_ra[0] = 8'd40; step("R5 next cycle");

    // R11: disabled write ports change nothing
    clear_stage();
    for (int p = 0; p < NWR; p++) begin s_wa[p] = 8'd40; s_wd[p] = 32'hDEAD_0000 + p; end
    step("R11 disabled write");
    clear_stage(); s_re = '1; s_ra = {8'd40, 8'd40, 8'd40, 8'd40}; step("R11 readback");

    // R8: clash flag
    clear_stage(); s_we[0] = 1'b1; s_we[2] = 1'b1; s_wa[0] = 8'd77; s_wa[2] = 8'd77;
    s_wd[0] = 32'h1; s_wd[2] = 32'h2; step("R8 clash");
    clear_stage(); s_we[1] = 1'b1; s_wa = {8'd77, 8'd77, 8'd77}; s_wd[1] = 32'h7777_0077;
    step("R8 disabled share");
    clear_stage(); s_re[2] = 1'b1; s_ra[2] = 8'd77; step("R8 rewrite read");

    // R2: random traffic with distinct write addresses
    for (int k = 0; k < 300; k++) begin
      int base, stride;
      clear_stage();
      base = $urandom % DEPTH;
      stride = 1 + ($urandom % 85);
      for (int p = 0; p < NWR; p++) begin
        s_we[p] = 1'(($urandom % 2));
        s_wa[p] = AW'(base + p * stride);
        s_wd[p] = $urandom;
      end
      for (int r = 0; r < NRD; r++) begin
        s_re[r] = 1'(($urandom % 4) != 0);
        s_ra[r] = (($urandom % 3) == 0) ? s_wa[r % NWR] : AW'($urandom);
      end
      step("R2 random");
    end

    clear_stage();
    step("drain");
    step("drain");
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule